// File: doc/BRIEF.md
# Bucketed Parallel-Compare Hash Lookup

This block is a small on-chip key/value table. Its storage is a grid of `BUCKETS` rows by `LINKS` slots, and each slot carries a key, a value and an occupied bit. A key always belongs to exactly one row, found by reducing the key modulo `BUCKETS`. To look up a key, the block reads that row and compares every slot against the key at once. Each slot passes its value only when it is occupied and its key matches; otherwise it passes zero. The result is the bitwise OR of all the gated slot values. There is no sequential probe, no chain walk and no priority multiplexer.

The same row logic serves inserts. An insert of a key that is already in its row rewrites the value in place. A new key goes to the lowest-numbered free slot of its row. If the row has no free slot, the table is left untouched and a one-cycle error is raised. Deletion, resizing and overflow chaining are not part of the block.

A small phase register records which operation the last cycle carried. It drives the outputs. The phases are `PH_IDLE` (no operation), `PH_LOOKUP` (a lookup was accepted, so the response is shown) and `PH_INSERT` (an insert was accepted, so the error flag may be shown). The next phase is chosen on every clock edge as follows:
- an insert request goes to `PH_INSERT`;
- a lookup with no insert goes to `PH_LOOKUP`;
- anything else goes to `PH_IDLE`.

Top module: `bucket_cam_lookup`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid`, `rsp_hit`, `rsp_value` and `ins_full_err` are all zero. Every slot starts empty.
- R2: A key is stored in, and looked up in, row (key mod `BUCKETS`) only. Each row holds at most `LINKS` keys, independently of the other rows.
- R3: A lookup accepted at a clock edge gives `rsp_valid` high for exactly the next cycle. `rsp_hit` is high and `rsp_value` equals the stored value when the key is present, including a stored value of zero.
- R4: A lookup of an absent key gives `rsp_valid` high, `rsp_hit` low and `rsp_value` zero. Whenever `rsp_valid` is low, `rsp_hit` and `rsp_value` are zero.
- R5: Empty slots never match, even when their key field equals the lookup key. For example, key 0 after reset misses.
- R6: Inserting a key already present in its row replaces its value and does not use another slot, so each key appears at most once per row.
- R7: Inserting a new key into a row whose `LINKS` slots are all occupied raises `ins_full_err` for exactly the next cycle and changes no stored key or value. Otherwise `ins_full_err` stays low.
- R8: When an insert and a lookup are presented in the same cycle, the insert is performed and the lookup is dropped: `rsp_valid` is low in the next cycle. A lookup in the following cycle sees the inserted entry.
- R9: Lookups presented on consecutive cycles each get their own response, one cycle later, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_key | input | KEY_W | Key to look up |
| ins_valid | input | 1 | Insert request |
| ins_key | input | KEY_W | Key to insert or update |
| ins_val | input | VAL_W | Value to store |
| rsp_valid | output | 1 | A lookup result is shown this cycle |
| rsp_hit | output | 1 | The looked-up key was found |
| rsp_value | output | VAL_W | Value found, zero on a miss |
| ins_full_err | output | 1 | The previous insert found its row full |

## Verification
Every result is due one clock edge after the cycle that carried its request:
- the lookup response appears in the cycle after the lookup;
- the full-row error appears in the cycle after the insert.

The bench drives exactly one request slot per cycle on the falling edge. For each slot it pushes exactly one expected output set into a queue, computed from its own model of the rows. The monitor samples shortly after the following rising edge and pops one item each cycle. Idle and dropped-lookup cycles are therefore checked as all-zero outputs.

// File: rtl/hl_pkg.sv
package hl_pkg;
    // What the previous cycle carried; selects what the outputs show.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LOOKUP = 2'd1,
        PH_INSERT = 2'd2
    } phase_e;
endpackage

// File: rtl/hl_hash.sv
module hl_hash #(
    parameter int KEY_W   = 8,
    parameter int BUCKETS = 3,
    parameter int ROW_W   = 2
) (
    input  logic [KEY_W-1:0] key,
    output logic [ROW_W-1:0] row
);
    localparam logic [KEY_W-1:0] BK = KEY_W'(BUCKETS);
    logic [KEY_W-1:0] rem;

    assign rem = key % BK;
    assign row = rem[ROW_W-1:0];
endmodule

// File: rtl/hl_row_match.sv
module hl_row_match #(
    parameter int KEY_W = 8,
    parameter int VAL_W = 8,
    parameter int LINKS = 2
) (
    input  logic [LINKS-1:0][KEY_W-1:0] row_keys,
    input  logic [LINKS-1:0][VAL_W-1:0] row_vals,
    input  logic [LINKS-1:0]            row_vld,
    input  logic [KEY_W-1:0]            key,
    output logic [LINKS-1:0]            sel,
    output logic [VAL_W-1:0]            value,
    output logic                        hit
);
    logic [LINKS-1:0][VAL_W-1:0] masked;

    // One comparator and one value gate per slot.
    for (genvar s = 0; s < LINKS; s++) begin : g_slot
        assign sel[s]    = row_vld[s] && (row_keys[s] == key);
        assign masked[s] = sel[s] ? row_vals[s] : '0;
    end

    // Bitwise OR across the gated slot values.
    always_comb begin
        value = '0;
        for (int s = 0; s < LINKS; s++) begin
            value = value | masked[s];
        end
    end

    assign hit = |sel;
endmodule

// File: rtl/hl_store.sv
module hl_store #(
    parameter int KEY_W   = 8,
    parameter int VAL_W   = 8,
    parameter int BUCKETS = 3,
    parameter int LINKS   = 2,
    parameter int ROW_W   = 2,
    parameter int SLOT_W  = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ROW_W-1:0]            wr_row,
    input  logic [SLOT_W-1:0]           wr_slot,
    input  logic [KEY_W-1:0]            wr_key,
    input  logic [VAL_W-1:0]            wr_val,
    input  logic [ROW_W-1:0]            a_row,
    input  logic [ROW_W-1:0]            b_row,
    output logic [LINKS-1:0][KEY_W-1:0] a_keys,
    output logic [LINKS-1:0][VAL_W-1:0] a_vals,
    output logic [LINKS-1:0]            a_vld,
    output logic [LINKS-1:0][KEY_W-1:0] b_keys,
    output logic [LINKS-1:0][VAL_W-1:0] b_vals,
    output logic [LINKS-1:0]            b_vld
);
    logic [BUCKETS-1:0][LINKS-1:0][KEY_W-1:0] key_q;
    logic [BUCKETS-1:0][LINKS-1:0][VAL_W-1:0] val_q;
    logic [BUCKETS-1:0][LINKS-1:0]            vld_q;

    // Storage: one register bank per row and slot.
    for (genvar b = 0; b < BUCKETS; b++) begin : g_row
        for (genvar s = 0; s < LINKS; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    key_q[b][s] <= '0;
                    val_q[b][s] <= '0;
                    vld_q[b][s] <= 1'b0;
                end else if (we && wr_row == ROW_W'(b) && wr_slot == SLOT_W'(s)) begin
                    key_q[b][s] <= wr_key;
                    val_q[b][s] <= wr_val;
                    vld_q[b][s] <= 1'b1;
                end
            end
        end
    end

    // Two row read ports: one for lookups, one for inserts.
    assign a_keys = key_q[a_row];
    assign a_vals = val_q[a_row];
    assign a_vld  = vld_q[a_row];
    assign b_keys = key_q[b_row];
    assign b_vals = val_q[b_row];
    assign b_vld  = vld_q[b_row];

    // R7: a refused (full-row) insert or an idle cycle leaves every stored field as it was.
    a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(key_q) && $stable(val_q) && $stable(vld_q)));
endmodule

// File: rtl/bucket_cam_lookup.sv
module bucket_cam_lookup #(
    parameter int KEY_W   = 8,
    parameter int VAL_W   = 8,
    parameter int BUCKETS = 3,
    parameter int LINKS   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [KEY_W-1:0] lk_key,
    input  logic             ins_valid,
    input  logic [KEY_W-1:0] ins_key,
    input  logic [VAL_W-1:0] ins_val,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [VAL_W-1:0] rsp_value,
    output logic             ins_full_err
);
    import hl_pkg::*;

    localparam int ROW_W  = (BUCKETS > 1) ? $clog2(BUCKETS) : 1;
    localparam int SLOT_W = (LINKS > 1) ? $clog2(LINKS) : 1;

    logic [ROW_W-1:0]            lk_row, ins_row;
    logic [LINKS-1:0][KEY_W-1:0] lk_keys, in_keys;
    logic [LINKS-1:0][VAL_W-1:0] lk_vals, in_vals;
    logic [LINKS-1:0]            lk_vld, in_vld;
    logic [LINKS-1:0]            lk_sel, in_sel;
    logic [VAL_W-1:0]            lk_value, in_value_unused;
    logic                        lk_hit, in_hit;
    logic [SLOT_W-1:0]           ins_slot;
    logic                        row_full, we;

    phase_e           phase_q, phase_d;
    logic             hit_q;
    logic [VAL_W-1:0] val_q;
    logic             full_q;

    // Row selection: key modulo BUCKETS, one hash per port.
    hl_hash #(.KEY_W(KEY_W), .BUCKETS(BUCKETS), .ROW_W(ROW_W)) u_hash_lk (
        .key (lk_key),
        .row (lk_row)
    );
    hl_hash #(.KEY_W(KEY_W), .BUCKETS(BUCKETS), .ROW_W(ROW_W)) u_hash_in (
        .key (ins_key),
        .row (ins_row)
    );

    hl_store #(
        .KEY_W(KEY_W), .VAL_W(VAL_W), .BUCKETS(BUCKETS), .LINKS(LINKS),
        .ROW_W(ROW_W), .SLOT_W(SLOT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .wr_row  (ins_row),
        .wr_slot (ins_slot),
        .wr_key  (ins_key),
        .wr_val  (ins_val),
        .a_row   (lk_row),
        .b_row   (ins_row),
        .a_keys  (lk_keys),
        .a_vals  (lk_vals),
        .a_vld   (lk_vld),
        .b_keys  (in_keys),
        .b_vals  (in_vals),
        .b_vld   (in_vld)
    );

    // Parallel compare of the lookup row.
    hl_row_match #(.KEY_W(KEY_W), .VAL_W(VAL_W), .LINKS(LINKS)) u_match_lk (
        .row_keys (lk_keys),
        .row_vals (lk_vals),
        .row_vld  (lk_vld),
        .key      (lk_key),
        .sel      (lk_sel),
        .value    (lk_value),
        .hit      (lk_hit)
    );

    // Parallel compare of the insert row (finds an existing copy of the key).
    hl_row_match #(.KEY_W(KEY_W), .VAL_W(VAL_W), .LINKS(LINKS)) u_match_in (
        .row_keys (in_keys),
        .row_vals (in_vals),
        .row_vld  (in_vld),
        .key      (ins_key),
        .sel      (in_sel),
        .value    (in_value_unused),
        .hit      (in_hit)
    );

    // Slot choice: the matching slot if the key exists, else the lowest empty slot.
    // The loop runs downward so that the lowest index is assigned last and wins.
    always_comb begin
        ins_slot = '0;
        for (int s = LINKS - 1; s >= 0; s--) begin
            if (in_hit ? in_sel[s] : !in_vld[s]) ins_slot = SLOT_W'(s);
        end
    end

    assign row_full = !in_hit && (&in_vld);
    assign we       = ins_valid && !row_full;

    // Next phase: an insert takes priority over a lookup in the same cycle.
    always_comb begin
        if (ins_valid)     phase_d = PH_INSERT;
        else if (lk_valid) phase_d = PH_LOOKUP;
        else               phase_d = PH_IDLE;
    end

    // State register, with the lookup result and insert outcome captured beside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            hit_q   <= 1'b0;
            val_q   <= '0;
            full_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            hit_q   <= lk_hit;
            val_q   <= lk_value;
            full_q  <= row_full;
        end
    end

    // Outputs, decoded from the phase.
    always_comb begin
        rsp_valid    = 1'b0;
        rsp_hit      = 1'b0;
        rsp_value    = '0;
        ins_full_err = 1'b0;
        unique case (phase_q)
            PH_IDLE: ;
            PH_LOOKUP: begin
                rsp_valid = 1'b1;
                rsp_hit   = hit_q;
                rsp_value = val_q;
            end
            PH_INSERT: ins_full_err = full_q;
            default: ;
        endcase
    end

    a_r3_resp_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid && !ins_valid));
    a_r4_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_value == '0));
    a_r6_key_once_per_row: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_sel));
    a_r7_err_needs_insert: assert property (@(posedge clk) disable iff (!rst_n)
        ins_full_err |-> $past(ins_valid));
    a_r8_insert_drops_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> !rsp_valid);
endmodule

// File: tb/tb_bucket_cam_lookup.sv
`timescale 1ns/1ps
module tb_bucket_cam_lookup;
    localparam int KEY_W = 8;
    localparam int VAL_W = 8;
    localparam int NB    = 3;
    localparam int NL    = 2;

    typedef struct {
        logic             v;
        logic             h;
        logic [VAL_W-1:0] d;
        logic             e;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0;
    logic [KEY_W-1:0] lk_key = '0;
    logic             ins_valid = 1'b0;
    logic [KEY_W-1:0] ins_key = '0;
    logic [VAL_W-1:0] ins_val = '0;
    logic             rsp_valid, rsp_hit, ins_full_err;
    logic [VAL_W-1:0] rsp_value;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;

    exp_t q[$];

    // Reference model of the table, kept by the bench.
    logic [KEY_W-1:0] mk [NB][NL];
    logic [VAL_W-1:0] mv [NB][NL];
    bit               mo [NB][NL];

    always #2.5 clk = ~clk;

    bucket_cam_lookup #(.KEY_W(KEY_W), .VAL_W(VAL_W), .BUCKETS(NB), .LINKS(NL)) dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_key(lk_key),
        .ins_valid(ins_valid), .ins_key(ins_key), .ins_val(ins_val),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_value(rsp_value),
        .ins_full_err(ins_full_err)
    );

    task automatic check(string tag, logic v, logic h, logic [VAL_W-1:0] d, logic e);
        compared++;
        if (rsp_valid !== v || rsp_hit !== h || rsp_value !== d || ins_full_err !== e) begin
            mismatched++;
            $display("FAIL %s: got valid=%b hit=%b value=%h err=%b, expected valid=%b hit=%b value=%h err=%b",
                     tag, rsp_valid, rsp_hit, rsp_value, ins_full_err, v, h, d, e);
        end
    endtask

    // Driver: one request slot per cycle. It computes the outcome from the model
    // and pushes what the outputs must show one edge later.
    task automatic step(bit lv, logic [KEY_W-1:0] lk, bit iv, logic [KEY_W-1:0] ik,
                        logic [VAL_W-1:0] ival, string tag);
        exp_t x;
        @(negedge clk);
        lk_valid  = lv;
        lk_key    = lk;
        ins_valid = iv;
        ins_key   = ik;
        ins_val   = ival;
        x.v = 0; x.h = 0; x.d = '0; x.e = 0; x.tag = tag;
        if (iv) begin
            int r;
            int slot;
            r = int'(ik) % NB;
            slot = -1;
            for (int s = 0; s < NL; s++) if (mo[r][s] && mk[r][s] == ik && slot < 0) slot = s;
            if (slot < 0) for (int s = 0; s < NL; s++) if (!mo[r][s] && slot < 0) slot = s;
            if (slot < 0) x.e = 1;
            else begin
                mk[r][slot] = ik;
                mv[r][slot] = ival;
                mo[r][slot] = 1;
            end
        end else if (lv) begin
            int r;
            r = int'(lk) % NB;
            x.v = 1;
            for (int s = 0; s < NL; s++) if (mo[r][s] && mk[r][s] == lk) begin
                x.h = 1;
                x.d = mv[r][s];
            end
        end
        q.push_back(x);
    endtask

    // Monitor: samples after each rising edge and pops one expectation per cycle.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t x;
                x = q.pop_front();
                check(x.tag, x.v, x.h, x.d, x.e);
            end
        end
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000 && !done) begin
                mismatched++;
                compared++;
                $display("FAIL watchdog: got timeout, expected completion");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        end
    end

    initial begin
        for (int b = 0; b < NB; b++)
            for (int s = 0; s < NL; s++) begin
                mk[b][s] = '0;
                mv[b][s] = '0;
                mo[b][s] = 0;
            end

        repeat (3) @(posedge clk);
        #1 check("R1 reset outputs", 0, 0, '0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 first cycle after reset", 0, 0, '0, 0);

        // R5: stored key fields are 0 after reset, but the slots are empty.
        step(1, 8'd0, 0, 0, 0, "R5 empty slot with key 0 misses");
        step(1, 8'd4, 0, 0, 0, "R4 miss on empty table");
        step(0, 0, 1, 8'd4, 8'h11, "R7 insert 4 into free slot");
        step(1, 8'd4, 0, 0, 0, "R3 hit key 4");
        step(1, 8'd7, 0, 0, 0, "R4 miss key 7 in same row");
        step(0, 0, 1, 8'd7, 8'h22, "R2 insert 7 fills row 1");
        step(0, 0, 1, 8'd10, 8'h33, "R7 row 1 full error on key 10");
        step(0, 0, 0, 0, 0, "R7 error lasts one cycle");
        step(1, 8'd10, 0, 0, 0, "R7 rejected key 10 absent");
        step(1, 8'd4, 0, 0, 0, "R7 key 4 unchanged after refusal");
        step(1, 8'd7, 0, 0, 0, "R7 key 7 unchanged after refusal");
        step(0, 0, 1, 8'd4, 8'h5A, "R6 update key 4 in full row");
        step(1, 8'd4, 0, 0, 0, "R6 key 4 new value");
        step(1, 8'd7, 0, 0, 0, "R6 key 7 kept");
        step(1, 8'd5, 1, 8'd5, 8'h66, "R8 lookup dropped by insert");
        step(1, 8'd5, 0, 0, 0, "R8 next lookup sees key 5");
        step(0, 0, 1, 8'd3, 8'h00, "R2 insert 3 into row 0");
        step(0, 0, 1, 8'd255, 8'h77, "R2 insert 255 into row 0");
        step(0, 0, 1, 8'd0, 8'h88, "R2 row 0 full on key 0");
        step(1, 8'd3, 0, 0, 0, "R3 hit with stored value zero");
        step(1, 8'd255, 0, 0, 0, "R2 key 255 maps to row 0");
        step(0, 0, 1, 8'd2, 8'h99, "R2 row 2 still has room");
        step(1, 8'd2, 0, 0, 0, "R9 back-to-back lookup 1");
        step(1, 8'd5, 0, 0, 0, "R9 back-to-back lookup 2");
        step(1, 8'd6, 0, 0, 0, "R9 back-to-back lookup 3 miss");
        step(1, 8'd4, 0, 0, 0, "R9 back-to-back lookup 4");
        step(0, 0, 0, 0, 0, "R4 idle outputs zero");
        step(0, 0, 0, 0, 0, "R4 idle outputs zero again");

        @(negedge clk);
        lk_valid = 0;
        ins_valid = 0;
        repeat (3) @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule